// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a synchronous DRAM interface. On every rising clock edge it samples clock enable, chip select, the three command strobes, the bank select bits and the address bus. It then names the command the controller issued in that cycle. To tell refresh from self-refresh and power-down from a normal command, it compares the present clock-enable level with the level from the cycle before.

Behind the classifier, one tracker per bank records whether the bank is idle, open, or closing under auto-precharge, and which row it holds open. A single burst timer tells when a read or write burst is still running. A small power-state machine follows the self-refresh and power-down conditions. A command that the current state does not allow produces an error strobe and changes nothing. The memory array and the data path are not part of this block.

Top module: `sdcmd_tracker`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets every bank to idle (code 0), every open-row field to zero, the power state to run (0), `cmd_o` to deselect (0) and `err_o` to 0. After reset the previous clock-enable sample reads as high.
- R2: When clock enable is high in both the previous and the present sample, `cs_n` high decodes as deselect (code 0). `cs_n` low with all three strobes high decodes as no-operation (code 1). The pattern with RAS and CAS high and WE low also decodes as no-operation (code 1). Neither command raises an error or changes a bank.
- R3: Bank states are encoded as 0 idle, 1 open, 2 closing under auto-precharge, with bank i in `bank_state_o[2i+1:2i]`. Row activate (`cs_n`/`ras_n` low, `cas_n`/`we_n` high, code 2) is legal only on an idle bank. It makes the bank open and stores `addr` in `open_rows_o[ADDR_W*i +: ADDR_W]`.
- R4: `cs_n`/`cas_n` low with `ras_n` high is a read when `we_n` is high and a write when `we_n` is low. With `addr[10]` low the codes are read 3 and write 5. With `addr[10]` high they are read with auto-precharge 4 and write with auto-precharge 6. Each is legal only on an open bank, and a legal one starts a burst of `BURST_LEN` cycles.
- R5: A legal auto-precharge access puts its bank in state 2. The bank returns to idle on the cycle its burst ends: either `BURST_LEN` edges after the access, or at the next legal read or write, which cuts the burst short. Any activate, read, write or single-bank precharge aimed at a bank in state 2 is illegal.
- R6: `cs_n`/`ras_n`/`we_n` low with `cas_n` high is a precharge. With `addr[10]` low it is code 7 and idles only the addressed bank. With `addr[10]` high it is code 8, idles all banks and ignores `ba`. Code 8 is illegal while any bank is in state 2.
- R7: All strobes low is mode register set (code 9). `cs_n`/`ras_n`/`cas_n` low with `we_n` high and clock enable steady high is auto refresh (code 10). Both are legal only when every bank is idle and no burst is running.
- R8: The auto-refresh pattern with clock enable falling from high to low is self-refresh entry (code 11). It needs the same idle condition as R7, and a legal entry sets the power state to self-refresh (2).
- R9: Clock enable falling with any other pattern is power-down entry (code 12). It is rejected while a burst is running. A legal entry sets the power state to power-down (1) and keeps the bank states.
- R10: With the previous clock-enable sample low, a high present sample while in power-down or self-refresh decodes as exit (code 13) and sets the power state to run. Every other cycle with a low previous sample decodes as hold (code 14) and has no effect.
- R11: Each illegal command raises `err_o` for exactly the cycle that reports it. The bank and power states are left as they were, apart from a burst that ends in that same cycle.
- R12: `cmd_o`, `err_o`, `bank_state_o`, `open_rows_o` and `pwr_o` are registered. They show the effect of the command sampled at an edge right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W (2) | Bank select |
| addr | input | ADDR_W (12) | Address; bit AP_BIT (10) selects auto-precharge / all banks |
| cmd_o | output | 4 | Decoded command code |
| err_o | output | 1 | Illegal-command strobe |
| bank_state_o | output | 2*NBANK (8) | Per-bank state, 2 bits each |
| open_rows_o | output | NBANK*ADDR_W (48) | Per-bank open row |
| pwr_o | output | 2 | Power state: 0 run, 1 power-down, 2 self-refresh |

## Verification
Some properties are checked on every cycle. A bank only becomes open through a legal activate aimed at it. A closing bank can only go back to idle. A legal precharge-all leaves every bank idle. Self-refresh never holds an open bank, and no burst runs in a low-power state. An exit always returns to run, and an error never moves the power state. The bench scenarios are the only evidence for the exact timing of auto-precharge closure, both after a full burst and after a burst cut short. The same holds for rejecting power-down entry during a burst, refusing refresh while the burst timer runs after a precharge, and the row values captured per bank.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_ACT   = 4'd2,
    CMD_RD    = 4'd3,
    CMD_RDA   = 4'd4,
    CMD_WR    = 4'd5,
    CMD_WRA   = 4'd6,
    CMD_PRE   = 4'd7,
    CMD_PALL  = 4'd8,
    CMD_MRS   = 4'd9,
    CMD_REF   = 4'd10,
    CMD_SREF  = 4'd11,
    CMD_PDN   = 4'd12,
    CMD_EXIT  = 4'd13,
    CMD_HOLD  = 4'd14
  } sd_cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE    = 2'd0,
    BK_OPEN    = 2'd1,
    BK_AUTOPRE = 2'd2
  } bank_st_e;

  typedef enum logic [1:0] {
    PW_RUN   = 2'd0,
    PW_PDOWN = 2'd1,
    PW_SELF  = 2'd2
  } pwr_e;

  // Names the command from the strobes and both clock-enable samples.
  function automatic sd_cmd_e classify(input logic cke_prev, input logic cke,
                                       input logic cs_n, input logic ras_n,
                                       input logic cas_n, input logic we_n,
                                       input logic ap, input pwr_e pw);
    sd_cmd_e c;
    if (!cke_prev) begin
      c = (cke && pw != PW_RUN) ? CMD_EXIT : CMD_HOLD;
    end else if (!cke) begin
      c = (!cs_n && !ras_n && !cas_n && we_n) ? CMD_SREF : CMD_PDN;
    end else if (cs_n) begin
      c = CMD_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  c = CMD_ACT;
        3'b101:  c = ap ? CMD_RDA : CMD_RD;
        3'b100:  c = ap ? CMD_WRA : CMD_WR;
        3'b010:  c = ap ? CMD_PALL : CMD_PRE;
        3'b000:  c = CMD_MRS;
        3'b001:  c = CMD_REF;
        default: c = CMD_NOP;
      endcase
    end
    return c;
  endfunction

  function automatic logic is_access(input sd_cmd_e c);
    return (c == CMD_RD) || (c == CMD_RDA) || (c == CMD_WR) || (c == CMD_WRA);
  endfunction

  // True when the command is not allowed in the present state.
  function automatic logic cmd_illegal(input sd_cmd_e c, input bank_st_e sel_st,
                                       input logic any_ap, input logic dev_idle,
                                       input logic busy);
    logic bad;
    case (c)
      CMD_ACT:                    bad = (sel_st != BK_IDLE);
      CMD_RD, CMD_RDA,
      CMD_WR, CMD_WRA:            bad = (sel_st != BK_OPEN);
      CMD_PRE:                    bad = (sel_st == BK_AUTOPRE);
      CMD_PALL:                   bad = any_ap;
      CMD_MRS, CMD_REF, CMD_SREF: bad = !dev_idle;
      CMD_PDN:                    bad = busy;
      default:                    bad = 1'b0;
    endcase
    return bad;
  endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
(
  input  logic    cke_prev,
  input  logic    cke,
  input  logic    cs_n,
  input  logic    ras_n,
  input  logic    cas_n,
  input  logic    we_n,
  input  logic    ap,
  input  pwr_e    pw,
  output sd_cmd_e cmd
);
  assign cmd = classify(cke_prev, cke, cs_n, ras_n, cas_n, we_n, ap, pw);
endmodule

// File: rtl/sdcmd_burst.sv
module sdcmd_burst #(
  parameter int BURST_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic active,
  output logic done
);
  localparam int CW = $clog2(BURST_LEN + 1);

  logic [CW-1:0] cnt;

  assign active = (cnt != '0);
  // A burst ends on its last beat or when a new burst interrupts it.
  assign done   = start ? active : (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (start)  cnt <= CW'(BURST_LEN);
    else if (active) cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              legal,
  input  logic              burst_done,
  input  sd_cmd_e           cmd,
  input  logic [ADDR_W-1:0] addr,
  output bank_st_e          state,
  output logic [ADDR_W-1:0] row
);
  logic hit;
  assign hit = legal && sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= BK_IDLE;
      row   <= '0;
    end else if (hit && cmd == CMD_ACT) begin
      state <= BK_OPEN;
      row   <= addr;
    end else if (hit && (cmd == CMD_RDA || cmd == CMD_WRA)) begin
      state <= BK_AUTOPRE;
    end else if ((hit && cmd == CMD_PRE) || (legal && cmd == CMD_PALL)) begin
      state <= BK_IDLE;
    end else if (burst_done && state == BK_AUTOPRE) begin
      state <= BK_IDLE;
    end
  end
endmodule

// File: rtl/sdcmd_power.sv
module sdcmd_power
  import sdcmd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cke,
  input  logic enter_pd,
  input  logic enter_sr,
  input  logic leave,
  output pwr_e pwr,
  output logic cke_prev
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pwr      <= PW_RUN;
      cke_prev <= 1'b1;
    end else begin
      cke_prev <= cke;
      if (leave)         pwr <= PW_RUN;
      else if (enter_sr) pwr <= PW_SELF;
      else if (enter_pd) pwr <= PW_PDOWN;
    end
  end
endmodule

// File: rtl/sdcmd_tracker.sv
module sdcmd_tracker
  import sdcmd_pkg::*;
#(
  parameter  int NBANK     = 4,
  parameter  int ADDR_W    = 12,
  parameter  int AP_BIT    = 10,
  parameter  int BURST_LEN = 4,
  localparam int BA_W      = $clog2(NBANK)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cke,
  input  logic                    cs_n,
  input  logic                    ras_n,
  input  logic                    cas_n,
  input  logic                    we_n,
  input  logic [BA_W-1:0]         ba,
  input  logic [ADDR_W-1:0]       addr,
  output logic [3:0]              cmd_o,
  output logic                    err_o,
  output logic [2*NBANK-1:0]      bank_state_o,
  output logic [NBANK*ADDR_W-1:0] open_rows_o,
  output logic [1:0]              pwr_o
);
  // Named internal events, also seen by the bound checker.
  logic              cke_prev;
  pwr_e              pwr;
  sd_cmd_e           cmd_now;
  logic              illegal_now;
  logic              legal_now;
  logic              burst_start;
  logic              burst_active;
  logic              burst_done;
  logic              any_ap;
  logic              all_idle;
  bank_st_e          sel_st;
  bank_st_e          bank_st  [NBANK];
  logic [ADDR_W-1:0] bank_row [NBANK];
  sd_cmd_e           cmd_q;
  logic              err_q;

  sdcmd_decode u_dec (
    .cke_prev (cke_prev),
    .cke      (cke),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .ap       (addr[AP_BIT]),
    .pw       (pwr),
    .cmd      (cmd_now)
  );

  always_comb begin
    any_ap   = 1'b0;
    all_idle = 1'b1;
    for (int i = 0; i < NBANK; i++) begin
      if (bank_st[i] == BK_AUTOPRE) any_ap = 1'b1;
      if (bank_st[i] != BK_IDLE)    all_idle = 1'b0;
    end
  end

  assign sel_st      = bank_st[ba];
  assign illegal_now = cmd_illegal(cmd_now, sel_st, any_ap,
                                   all_idle && !burst_active, burst_active);
  assign legal_now   = !illegal_now;
  assign burst_start = legal_now && is_access(cmd_now);

  sdcmd_burst #(.BURST_LEN(BURST_LEN)) u_burst (
    .clk    (clk),
    .rst    (rst),
    .start  (burst_start),
    .active (burst_active),
    .done   (burst_done)
  );

  sdcmd_power u_pwr (
    .clk      (clk),
    .rst      (rst),
    .cke      (cke),
    .enter_pd (legal_now && cmd_now == CMD_PDN),
    .enter_sr (legal_now && cmd_now == CMD_SREF),
    .leave    (cmd_now == CMD_EXIT),
    .pwr      (pwr),
    .cke_prev (cke_prev)
  );

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    sdcmd_bank #(.ADDR_W(ADDR_W)) u_bank (
      .clk        (clk),
      .rst        (rst),
      .sel        (ba == BA_W'(i)),
      .legal      (legal_now),
      .burst_done (burst_done),
      .cmd        (cmd_now),
      .addr       (addr),
      .state      (bank_st[i]),
      .row        (bank_row[i])
    );
    assign bank_state_o[2*i +: 2]          = bank_st[i];
    assign open_rows_o[ADDR_W*i +: ADDR_W] = bank_row[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= CMD_DESEL;
      err_q <= 1'b0;
    end else begin
      cmd_q <= cmd_now;
      err_q <= illegal_now;
    end
  end

  assign cmd_o = cmd_q;
  assign err_o = err_q;
  assign pwr_o = pwr;
endmodule

// File: rtl/sdcmd_checker.sv
module sdcmd_checker
  import sdcmd_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int BA_W  = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [3:0]         cmd_o,
  input logic               err_o,
  input logic [2*NBANK-1:0] bank_state_o,
  input logic [1:0]         pwr_o,
  input logic [BA_W-1:0]    ba,
  input logic               burst_active
);
  for (genvar i = 0; i < NBANK; i++) begin : g_chk
    a_r3_open_only_by_act: assert property (@(posedge clk) disable iff (rst)
      (bank_state_o[2*i +: 2] == 2'(BK_OPEN) && $past(bank_state_o[2*i +: 2]) != 2'(BK_OPEN))
      |-> (cmd_o == 4'(CMD_ACT) && !err_o && $past(ba) == BA_W'(i)));

    a_r5_closing_goes_idle: assert property (@(posedge clk) disable iff (rst)
      ($past(bank_state_o[2*i +: 2]) == 2'(BK_AUTOPRE) && bank_state_o[2*i +: 2] != 2'(BK_AUTOPRE))
      |-> bank_state_o[2*i +: 2] == 2'(BK_IDLE));
  end

  a_r2_quiet_no_error: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 4'(CMD_DESEL) || cmd_o == 4'(CMD_NOP)) |-> !err_o);

  a_r6_all_banks_idle: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 4'(CMD_PALL) && !err_o) |-> bank_state_o == '0);

  a_r8_self_refresh_idle: assert property (@(posedge clk) disable iff (rst)
    (pwr_o == 2'(PW_SELF)) |-> bank_state_o == '0);

  a_r9_no_burst_low_power: assert property (@(posedge clk) disable iff (rst)
    (pwr_o != 2'(PW_RUN)) |-> !burst_active);

  a_r10_exit_to_run: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 4'(CMD_EXIT)) |-> (pwr_o == 2'(PW_RUN) && $past(pwr_o) != 2'(PW_RUN)));

  a_r11_error_keeps_power: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $stable(pwr_o));
endmodule

bind sdcmd_tracker sdcmd_checker #(.NBANK(NBANK), .BA_W(BA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmd_o        (cmd_o),
  .err_o        (err_o),
  .bank_state_o (bank_state_o),
  .pwr_o        (pwr_o),
  .ba           (ba),
  .burst_active (burst_active)
);

// File: tb/sim_sdcmd_tracker.sv
`timescale 1ns/1ps
module sim_sdcmd_tracker;
  localparam int BL = 4;
  localparam logic [3:0] P_DES = 4'b1111, P_NOP = 4'b0111, P_BST = 4'b0110,
                         P_ACT = 4'b0011, P_RD  = 4'b0101, P_WR  = 4'b0100,
                         P_PRE = 4'b0010, P_MRS = 4'b0000, P_REF = 4'b0001;

  logic clk = 1'b0, rst = 1'b1;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [3:0]  cmd_o;
  logic        err_o;
  logic [7:0]  bank_state_o;
  logic [47:0] open_rows_o;
  logic [1:0]  pwr_o;

  sdcmd_tracker u0 (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .cmd_o(cmd_o), .err_o(err_o),
    .bank_state_o(bank_state_o), .open_rows_o(open_rows_o), .pwr_o(pwr_o)
  );

  always #2 clk = ~clk;

  typedef struct packed {
    logic [3:0]  cmd;
    logic        err;
    logic [7:0]  banks;
    logic [47:0] rows;
    logic [1:0]  pwr;
  } exp_t;

  exp_t  sb [$];
  string tq [$];
  int    checks = 0, fails = 0;
  bit    finished = 0;

  // Reference state, kept by the bench from the requirements.
  int          m_bs [4];
  logic [11:0] m_row [4];
  int          m_pwr = 0, m_bcnt = 0;
  bit          m_ckep = 1;

  function automatic int code_of(bit ck, logic [3:0] p, bit a10);
    if (!m_ckep) return (ck && m_pwr != 0) ? 13 : 14;   // R10
    if (!ck) return (p == P_REF) ? 11 : 12;              // R8, R9
    if (p[3]) return 0;
    case (p)
      P_ACT:   return 2;
      P_RD:    return a10 ? 4 : 3;
      P_WR:    return a10 ? 6 : 5;
      P_PRE:   return a10 ? 8 : 7;
      P_MRS:   return 9;
      P_REF:   return 10;
      default: return 1;
    endcase
  endfunction

  // Driver: presents one command and queues what the outputs must show.
  task automatic put(input bit ck, input logic [3:0] p, input int bk,
                     input logic [11:0] a, input string tag);
    int c; bit bad, busy, anyap, idle, start, done; exp_t e;
    @(negedge clk);
    cke = ck; {cs_n, ras_n, cas_n, we_n} = p; ba = 2'(bk); addr = a;
    c = code_of(ck, p, a[10]);
    busy = (m_bcnt > 0); anyap = 0; idle = 1;
    for (int i = 0; i < 4; i++) begin
      if (m_bs[i] == 2) anyap = 1;
      if (m_bs[i] != 0) idle = 0;
    end
    case (c)
      2:          bad = (m_bs[bk] != 0);
      3, 4, 5, 6: bad = (m_bs[bk] != 1);
      7:          bad = (m_bs[bk] == 2);
      8:          bad = anyap;
      9, 10, 11:  bad = !(idle && !busy);
      12:         bad = busy;
      default:    bad = 0;
    endcase
    start = !bad && (c >= 3 && c <= 6);
    done  = start ? busy : (m_bcnt == 1);
    for (int i = 0; i < 4; i++) if (done && m_bs[i] == 2) m_bs[i] = 0;
    if (!bad) begin
      case (c)
        2:    begin m_bs[bk] = 1; m_row[bk] = a; end
        4, 6: m_bs[bk] = 2;
        7:    m_bs[bk] = 0;
        8:    for (int i = 0; i < 4; i++) m_bs[i] = 0;
        11:   m_pwr = 2;
        12:   m_pwr = 1;
        13:   m_pwr = 0;
        default: ;
      endcase
    end
    m_bcnt = start ? BL : (busy ? m_bcnt - 1 : 0);
    m_ckep = ck;
    e.cmd = 4'(c); e.err = bad; e.pwr = 2'(m_pwr);
    for (int i = 0; i < 4; i++) begin
      e.banks[2*i +: 2] = 2'(m_bs[i]);
      e.rows[12*i +: 12] = m_row[i];
    end
    sb.push_back(e);
    tq.push_back(tag);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // Monitor, R12: outputs reflect a command one ns after the edge sampling it.
  initial begin
    forever begin
      exp_t  e;
      exp_t  g;
      string t;
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        t = tq.pop_front();
        g = {cmd_o, err_o, bank_state_o, open_rows_o, pwr_o};
        checks++;
        if (g !== e) begin
          fails++;
          $display("FAIL %s: got cmd=%0d err=%0d banks=%h rows=%h pwr=%0d expected cmd=%0d err=%0d banks=%h rows=%h pwr=%0d",
                   t, g.cmd, g.err, g.banks, g.rows, g.pwr, e.cmd, e.err, e.banks, e.rows, e.pwr);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got run still active expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_bs[i] = 0; m_row[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({cmd_o, err_o, bank_state_o, open_rows_o, pwr_o} !== '0) begin
      fails++;
      $display("FAIL R1: got %h expected 0", {cmd_o, err_o, bank_state_o, open_rows_o, pwr_o});
    end
    rst = 1'b0;

    put(1, P_NOP, 0, 12'h000, "R2 nop");
    put(1, P_DES, 2, 12'h400, "R2 deselect");
    put(1, P_BST, 1, 12'h000, "R2 stop pattern");
    put(1, P_ACT, 0, 12'h123, "R3 activate b0");
    put(1, P_ACT, 0, 12'h321, "R3 R11 activate open bank");
    put(1, P_ACT, 1, 12'h055, "R3 activate b1");
    put(1, P_RD,  0, 12'h000, "R4 read");
    put(0, P_NOP, 0, 12'h000, "R9 power-down during burst");
    put(1, P_NOP, 0, 12'h000, "R10 hold after refused entry");
    put(1, P_WR,  2, 12'h000, "R4 write idle bank");
    put(1, P_RD,  3, 12'h400, "R4 read idle bank");
    put(1, P_RD,  1, 12'h400, "R4 R5 read autoprecharge");
    put(1, P_ACT, 1, 12'h077, "R5 activate closing bank");
    put(1, P_RD,  1, 12'h000, "R5 read closing bank");
    put(1, P_NOP, 0, 12'h000, "R5 still closing");
    put(1, P_NOP, 0, 12'h000, "R5 closes at burst end");
    put(1, P_PRE, 0, 12'h000, "R6 single precharge");
    put(1, P_ACT, 0, 12'h2AA, "R3 reopen b0");
    put(1, P_ACT, 2, 12'h155, "R3 activate b2");
    put(1, P_MRS, 0, 12'h000, "R7 mode set with open bank");
    put(1, P_PRE, 3, 12'h400, "R6 precharge all");
    put(1, P_MRS, 0, 12'h000, "R7 mode set idle");
    put(1, P_REF, 0, 12'h000, "R7 refresh idle");
    put(1, P_ACT, 0, 12'h0F0, "R3 activate b0 again");
    put(1, P_RD,  0, 12'h000, "R4 read b0");
    put(1, P_PRE, 0, 12'h000, "R6 precharge mid burst");
    put(1, P_REF, 0, 12'h000, "R7 refresh while burst runs");
    put(1, P_NOP, 0, 12'h000, "R12 drain");
    put(1, P_NOP, 0, 12'h000, "R12 drain");
    put(1, P_ACT, 3, 12'h3C3, "R3 activate b3");
    put(0, P_REF, 0, 12'h000, "R8 self-refresh with open bank");
    put(0, P_NOP, 0, 12'h000, "R10 hold low");
    put(1, P_NOP, 0, 12'h000, "R10 rise in run is hold");
    put(1, P_PRE, 3, 12'h000, "R6 precharge b3");
    put(0, P_REF, 0, 12'h000, "R8 self-refresh entry");
    put(0, P_DES, 0, 12'h000, "R10 hold in self-refresh");
    put(0, P_DES, 0, 12'h000, "R10 hold in self-refresh");
    put(1, P_DES, 0, 12'h000, "R10 exit self-refresh");
    put(1, P_ACT, 3, 12'h0AB, "R3 activate b3 again");
    put(0, P_DES, 0, 12'h000, "R9 power-down entry");
    put(0, P_NOP, 0, 12'h000, "R10 hold in power-down");
    put(1, P_NOP, 0, 12'h000, "R10 exit power-down");
    put(1, P_WR,  3, 12'h400, "R4 R5 write autoprecharge");
    put(1, P_ACT, 2, 12'h011, "R3 activate b2 in burst");
    put(1, P_WR,  2, 12'h000, "R5 interrupt closes b3");
    put(1, P_ACT, 3, 12'h022, "R5 b3 idle again");
    put(1, P_NOP, 0, 12'h000, "R12 drain");

    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R12: got %0d pending expected 0", sb.size());
    end
    finished = 1;
    summary();
    $finish;
  end
endmodule